// File: doc/BRIEF.md
# Transmit Buffer Bid Arbiter

This block decides whether the host may place an outgoing frame into the shared on-chip packet buffer. The host makes a bid in two steps: it writes a transmit command, then the frame length. The block checks the length, converts it to 256-byte pages and compares that count with the pages still free. Readiness is shown in two places. A polled ready bit in the bus-status word suits software that polls. A separate sticky ready event suits software that waits for an interrupt. The event is raised when a bid that was first short of space later fits.

Buffer space is taken in two phases. Accepting a bid reserves nothing. The pages are committed only when the host reads a status or event word that shows ready while that bid is still pending. On that read the block emits a one-cycle commit pulse with the page count, for the data-moving logic. The pages come back when the transmit side reports a finished frame. That report also sets a transmit-OK event, which can raise the interrupt.

All registers sit behind a pointer/data port pair. With `bus_sel` low the access goes to the pointer. With it high the access goes to the register that the pointer names: bus status 0x0138, transmit command 0x0140, transmit length 0x0142, transmit config 0x0110, buffer config 0x0112, transmit event 0x0120, buffer event 0x0122.

Top module: `txb_arbiter`

## Requirements
- R1: A bid is a write to the command register followed by a write to the length register. A length write with no command before it does nothing: bus-status bits 7 and 8 stay as they were and no commit occurs.
- R2: A length of 0 or above 1514 drops the bid and sets bus-status bit 7 (bid error). A later valid length clears bit 7.
- R3: Bus-status bit 8 (polled ready) reads 1 exactly while an accepted bid is uncommitted and the free pages are at least ceil(length/256). This includes the case where space frees up after the bid.
- R4: Suppose a bid is short of space and buffer-config bit 8 (ready interrupt enable) is set. When enough pages become free, buffer-event bit 8 is set one cycle later and `irq` rises.
- R5: Pages are committed only on a data-port read of bus status with bit 8 at 1, or of buffer event with bit 8 at 1, while a bid is pending. On that read `commit_pulse` is high and `commit_pages` holds the page count. The count is subtracted from the free pages at the clock edge, and the bid then ends. The buffer starts with BUF_PAGES free pages.
- R6: A `tx_done` pulse returns `tx_done_pages` to the free pool and sets transmit-event bit 8 (transmit OK). If transmit-config bit 8 is set, `irq` is raised.
- R7: A data-port read of an event register returns its flag and clears it, unless a new set arrives in that same cycle. `irq` is high exactly while some flag is set and its enable is set.
- R8: A command write while an earlier bid is pending and uncommitted cancels that bid. Polled ready then reads 0 until a new length is accepted.
- R9: After reset, every flag, enable and bid is clear. A pointer-port read returns the last pointer written. Reads at unmapped pointers return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_sel | input | 1 | 0 selects the pointer port, 1 the data port |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; read side effects happen at its clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the pointer and register state |
| tx_done | input | 1 | Frame sent pulse from the transmit side |
| tx_done_pages | input | PGW | Pages released by the finished frame |
| commit_pulse | output | 1 | Buffer space committed this cycle |
| commit_pages | output | PGW | Pages committed, valid with commit_pulse |
| irq | output | 1 | Interrupt, OR of the enabled event flags |

## Verification
Errors in the free-page count or the bid state do not stay hidden for long. A wrong count shows on the next bid: polled ready rises for a frame that should not fit, or stays low for one that should, and the next commit carries a wrong page count on `commit_pages`. A bid that is left pending or dropped by mistake shows at the very next status read, as a wrong bit 8 or a commit pulse that should not be there. A wrong event flag shows on `irq` one cycle after the freeing or done pulse that should, or should not, have set it.

// File: rtl/txb_pkg.sv
package txb_pkg;
  localparam logic [15:0] A_STATUS = 16'h0138;
  localparam logic [15:0] A_CMD    = 16'h0140;
  localparam logic [15:0] A_LEN    = 16'h0142;
  localparam logic [15:0] A_TXCFG  = 16'h0110;
  localparam logic [15:0] A_BUFCFG = 16'h0112;
  localparam logic [15:0] A_TXEVT  = 16'h0120;
  localparam logic [15:0] A_BUFEVT = 16'h0122;

  localparam int B_BIDERR = 7;
  localparam int B_READY  = 8;

  typedef enum logic [1:0] {
    BID_IDLE  = 2'd0,
    BID_ARMED = 2'd1,
    BID_PEND  = 2'd2
  } bid_state_e;
endpackage

// File: rtl/txb_regif.sv
module txb_regif
  import txb_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          st_ready,
  input  logic          st_biderr,
  input  logic          rdy_flag,
  input  logic          txok_flag,
  output logic          cmd_wr,
  output logic          len_wr,
  output logic          rd_status,
  output logic          rd_bufevt,
  output logic          rd_txevt,
  output logic          rdy_ie,
  output logic          txok_ie
);
  logic [DW-1:0] ptr_q, ptr_d;
  logic          rdy_ie_d, txok_ie_d;
  logic          dwr, drd;

  assign dwr       = bus_wr & bus_sel;
  assign drd       = bus_rd & bus_sel;
  assign cmd_wr    = dwr && (ptr_q == A_CMD);
  assign len_wr    = dwr && (ptr_q == A_LEN);
  assign rd_status = drd && (ptr_q == A_STATUS);
  assign rd_bufevt = drd && (ptr_q == A_BUFEVT);
  assign rd_txevt  = drd && (ptr_q == A_TXEVT);

  always_comb begin
    ptr_d     = ptr_q;
    rdy_ie_d  = rdy_ie;
    txok_ie_d = txok_ie;
    if (bus_wr && !bus_sel) ptr_d = bus_wdata;
    if (dwr && ptr_q == A_BUFCFG) rdy_ie_d = bus_wdata[B_READY];
    if (dwr && ptr_q == A_TXCFG) txok_ie_d = bus_wdata[B_READY];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      rdy_ie  <= 1'b0;
      txok_ie <= 1'b0;
    end else begin
      ptr_q   <= ptr_d;
      rdy_ie  <= rdy_ie_d;
      txok_ie <= txok_ie_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (!bus_sel) begin
      bus_rdata = ptr_q;
    end else begin
      case (ptr_q)
        A_STATUS: begin
          bus_rdata[B_READY]  = st_ready;
          bus_rdata[B_BIDERR] = st_biderr;
        end
        A_BUFCFG: bus_rdata[B_READY] = rdy_ie;
        A_TXCFG:  bus_rdata[B_READY] = txok_ie;
        A_BUFEVT: bus_rdata[B_READY] = rdy_flag;
        A_TXEVT:  bus_rdata[B_READY] = txok_flag;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/txb_bid_fsm.sv
module txb_bid_fsm
  import txb_pkg::*;
#(
  parameter int DW        = 16,
  parameter int PGW       = 5,
  parameter int PAGE_LOG2 = 8,
  parameter int MAX_LEN   = 1514
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_wr,
  input  logic           len_wr,
  input  logic [DW-1:0]  wdata,
  input  logic [PGW-1:0] free_pages,
  input  logic           rdy_ie,
  input  logic           rd_status,
  input  logic           rd_bufevt,
  input  logic           rdy_flag,
  output logic           ready_now,
  output logic           bid_err,
  output logic           pending,
  output logic           armed,
  output logic           commit,
  output logic [PGW-1:0] need_pages,
  output logic           space_ev
);
  localparam int PAGE_BYTES = 1 << PAGE_LOG2;

  bid_state_e     state_q, state_d;
  logic [PGW-1:0] need_q, need_d, need_calc;
  logic           err_d, wait_q, wait_d, len_bad, fits;

  assign len_bad    = (wdata == '0) || (32'(wdata) > MAX_LEN);
  assign need_calc  = PGW'((32'(wdata) + PAGE_BYTES - 1) >> PAGE_LOG2);
  assign pending    = (state_q == BID_PEND);
  assign armed      = (state_q == BID_ARMED);
  assign fits       = (free_pages >= need_q);
  assign ready_now  = pending && fits;
  assign commit     = pending && ((rd_status && ready_now) || (rd_bufevt && rdy_flag));
  assign space_ev   = pending && wait_q && fits;
  assign need_pages = need_q;

  always_comb begin
    state_d = state_q;
    need_d  = need_q;
    err_d   = bid_err;
    wait_d  = wait_q && !space_ev;
    if (cmd_wr) begin
      state_d = BID_ARMED;
      wait_d  = 1'b0;
    end else if (len_wr && armed) begin
      if (len_bad) begin
        state_d = BID_IDLE;
        err_d   = 1'b1;
      end else begin
        state_d = BID_PEND;
        need_d  = need_calc;
        err_d   = 1'b0;
        wait_d  = rdy_ie && (free_pages < need_calc);
      end
    end else if (commit) begin
      state_d = BID_IDLE;
      wait_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BID_IDLE;
      need_q  <= '0;
      bid_err <= 1'b0;
      wait_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      need_q  <= need_d;
      bid_err <= err_d;
      wait_q  <= wait_d;
    end
  end
endmodule

// File: rtl/txb_space.sv
module txb_space #(
  parameter int BUF_PAGES = 16,
  parameter int PGW       = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic [PGW-1:0] take_pages,
  input  logic           give,
  input  logic [PGW-1:0] give_pages,
  output logic [PGW-1:0] free_pages
);
  logic [PGW-1:0] free_d;

  always_comb begin
    free_d = free_pages;
    if (give) free_d = free_d + give_pages;
    if (take) free_d = free_d - take_pages;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) free_pages <= PGW'(BUF_PAGES);
    else        free_pages <= free_d;
  end
endmodule

// File: rtl/txb_events.sv
module txb_events (
  input  logic clk,
  input  logic rst_n,
  input  logic space_ev,
  input  logic tx_done,
  input  logic rd_bufevt,
  input  logic rd_txevt,
  input  logic rdy_ie,
  input  logic txok_ie,
  output logic rdy_flag,
  output logic txok_flag,
  output logic irq
);
  logic rdy_d, txok_d;

  always_comb begin
    rdy_d  = space_ev || (rdy_flag && !rd_bufevt);
    txok_d = tx_done || (txok_flag && !rd_txevt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_flag  <= 1'b0;
      txok_flag <= 1'b0;
    end else begin
      rdy_flag  <= rdy_d;
      txok_flag <= txok_d;
    end
  end

  assign irq = (rdy_flag && rdy_ie) || (txok_flag && txok_ie);
endmodule

// File: rtl/txb_arbiter.sv
module txb_arbiter #(
  parameter int DW        = 16,
  parameter int BUF_PAGES = 16,
  parameter int PAGE_LOG2 = 8,
  parameter int MAX_LEN   = 1514,
  localparam int PGW      = $clog2(BUF_PAGES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic           tx_done,
  input  logic [PGW-1:0] tx_done_pages,
  output logic           commit_pulse,
  output logic [PGW-1:0] commit_pages,
  output logic           irq
);
  logic           cmd_wr, len_wr, rd_status, rd_bufevt, rd_txevt;
  logic           rdy_ie, txok_ie, rdy_flag, txok_flag;
  logic           ready_now, bid_err, pending, armed, space_ev;
  logic [PGW-1:0] free_pages;

  txb_regif #(.DW(DW)) u_regif (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .st_ready(ready_now), .st_biderr(bid_err), .rdy_flag(rdy_flag),
    .txok_flag(txok_flag), .cmd_wr(cmd_wr), .len_wr(len_wr),
    .rd_status(rd_status), .rd_bufevt(rd_bufevt), .rd_txevt(rd_txevt),
    .rdy_ie(rdy_ie), .txok_ie(txok_ie)
  );

  txb_bid_fsm #(.DW(DW), .PGW(PGW), .PAGE_LOG2(PAGE_LOG2), .MAX_LEN(MAX_LEN)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .len_wr(len_wr),
    .wdata(bus_wdata), .free_pages(free_pages), .rdy_ie(rdy_ie),
    .rd_status(rd_status), .rd_bufevt(rd_bufevt), .rdy_flag(rdy_flag),
    .ready_now(ready_now), .bid_err(bid_err), .pending(pending),
    .armed(armed), .commit(commit_pulse), .need_pages(commit_pages),
    .space_ev(space_ev)
  );

  txb_space #(.BUF_PAGES(BUF_PAGES), .PGW(PGW)) u_space (
    .clk(clk), .rst_n(rst_n), .take(commit_pulse), .take_pages(commit_pages),
    .give(tx_done), .give_pages(tx_done_pages), .free_pages(free_pages)
  );

  txb_events u_events (
    .clk(clk), .rst_n(rst_n), .space_ev(space_ev), .tx_done(tx_done),
    .rd_bufevt(rd_bufevt), .rd_txevt(rd_txevt), .rdy_ie(rdy_ie),
    .txok_ie(txok_ie), .rdy_flag(rdy_flag), .txok_flag(txok_flag), .irq(irq)
  );
endmodule

// File: rtl/txb_arbiter_chk.sv
module txb_arbiter_chk #(
  parameter int DW        = 16,
  parameter int BUF_PAGES = 16,
  parameter int MAX_LEN   = 1514,
  parameter int PGW       = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_sel,
  input logic           bus_rd,
  input logic [DW-1:0]  bus_wdata,
  input logic           cmd_wr,
  input logic           len_wr,
  input logic           rd_txevt,
  input logic           armed,
  input logic           pending,
  input logic           bid_err,
  input logic [PGW-1:0] free_pages,
  input logic           commit_pulse,
  input logic [PGW-1:0] commit_pages,
  input logic           tx_done,
  input logic [PGW-1:0] tx_done_pages,
  input logic           txok_flag
);
  logic bad_len;
  assign bad_len = (bus_wdata == '0) || (32'(bus_wdata) > MAX_LEN);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    32'(free_pages) <= BUF_PAGES); // R5
  AST_BAD_LEN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (len_wr && armed && bad_len) |=> (bid_err && !pending)); // R2
  AST_COMMIT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> (bus_rd && bus_sel)); // R5
  AST_COMMIT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_pulse && !tx_done) |=> (free_pages == $past(free_pages) - $past(commit_pages))); // R5
  AST_DONE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !commit_pulse) |=> (free_pages == $past(free_pages) + $past(tx_done_pages))); // R6
  AST_TXOK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> txok_flag); // R6
  AST_EVT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_txevt && !tx_done) |=> !txok_flag); // R7
  AST_BID_REPLACED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> !pending); // R8
endmodule

bind txb_arbiter txb_arbiter_chk #(
  .DW(DW), .BUF_PAGES(BUF_PAGES), .MAX_LEN(MAX_LEN), .PGW(PGW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .cmd_wr(cmd_wr), .len_wr(len_wr),
  .rd_txevt(rd_txevt), .armed(armed), .pending(pending), .bid_err(bid_err),
  .free_pages(free_pages), .commit_pulse(commit_pulse),
  .commit_pages(commit_pages), .tx_done(tx_done),
  .tx_done_pages(tx_done_pages), .txok_flag(txok_flag)
);

// File: tb/txb_arbiter_tb.sv
module txb_arbiter_tb;
  localparam int PGW = 5;
  localparam logic [15:0] P_STATUS = 16'h0138, P_CMD = 16'h0140, P_LEN = 16'h0142,
                          P_TXCFG = 16'h0110, P_BUFCFG = 16'h0112,
                          P_TXEVT = 16'h0120, P_BUFEVT = 16'h0122;

  logic clk, rst_n, bus_sel, bus_wr, bus_rd, tx_done, commit_pulse, irq;
  logic [15:0] bus_wdata, bus_rdata;
  logic [PGW-1:0] tx_done_pages, commit_pages;
  int n_vec, n_bad;
  bit finished;

  txb_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_done(tx_done), .tx_done_pages(tx_done_pages),
    .commit_pulse(commit_pulse), .commit_pages(commit_pages), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic sel, input logic [15:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_write(input logic [15:0] a, input logic [15:0] d);
    bus_write(1'b0, a);
    bus_write(1'b1, d);
  endtask

  // returns read data, commit pulse and page count seen during the read cycle
  task automatic reg_read(input logic [15:0] a, output logic [15:0] v,
                          output logic cp, output logic [PGW-1:0] pg);
    bus_write(1'b0, a);
    bus_sel = 1'b1; bus_rd = 1'b1;
    #1;
    v = bus_rdata; cp = commit_pulse; pg = commit_pages;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic bid(input logic [15:0] len);
    reg_write(P_CMD, 16'h0001);
    reg_write(P_LEN, len);
  endtask

  task automatic done_pulse(input logic [PGW-1:0] pg);
    @(negedge clk);
    tx_done = 1'b1; tx_done_pages = pg;
    @(negedge clk);
    tx_done = 1'b0; tx_done_pages = '0;
  endtask

  task automatic t_reset();
    logic [15:0] v; logic cp; logic [PGW-1:0] pg;
    check("R9 irq after reset", irq, 0);
    reg_read(P_STATUS, v, cp, pg);
    check("R9 status after reset", v, 0);
    bus_write(1'b0, 16'h0077);
    bus_sel = 1'b0; #1;
    check("R9 pointer readback", bus_rdata, 16'h0077);
    reg_read(16'h0077, v, cp, pg);
    check("R9 unmapped reads zero", v, 0);
  endtask

  task automatic t_len_no_cmd();
    logic [15:0] v; logic cp; logic [PGW-1:0] pg;
    reg_write(P_LEN, 16'd100);
    reg_read(P_STATUS, v, cp, pg);
    check("R1 length without command ignored", v, 0);
    check("R1 no commit", cp, 0);
  endtask

  task automatic t_bad_len();
    logic [15:0] v; logic cp; logic [PGW-1:0] pg;
    bid(16'd0);
    reg_read(P_STATUS, v, cp, pg);
    check("R2 zero length error", v, 16'h0080);
    bid(16'd1515);
    reg_read(P_STATUS, v, cp, pg);
    check("R2 oversize length error", v, 16'h0080);
    check("R2 no commit on error", cp, 0);
  endtask

  task automatic t_polled();
    logic [15:0] v; logic cp; logic [PGW-1:0] pg;
    bid(16'd1514);
    reg_read(P_STATUS, v, cp, pg);
    check("R3 ready, R2 error cleared", v, 16'h0100);
    check("R5 commit on ready read", cp, 1);
    check("R5 pages for 1514", pg, 6);
    reg_read(P_STATUS, v, cp, pg);
    check("R5 bid ends after commit", v, 0);
    check("R5 single commit", cp, 0);
  endtask

  task automatic t_poll_after_free();
    logic [15:0] v; logic cp; logic [PGW-1:0] pg;
    bid(16'd1514);
    reg_read(P_STATUS, v, cp, pg);
    check("R5 second commit", pg, 6);          // free 4
    bid(16'd1100);                              // needs 5
    reg_read(P_STATUS, v, cp, pg);
    check("R3 short of space", v, 0);
    check("R5 no commit while short", cp, 0);
    done_pulse(5'd6);                           // free 10
    reg_read(P_STATUS, v, cp, pg);
    check("R3 ready after space freed", v, 16'h0100);
    check("R5 pages for 1100", pg, 5);          // free 5
    check("R7 txok without enable no irq", irq, 0);
    reg_read(P_TXEVT, v, cp, pg);
    check("R6 txok flag", v, 16'h0100);
    reg_read(P_TXEVT, v, cp, pg);
    check("R7 txok cleared by read", v, 0);
  endtask

  task automatic t_irq_ready();
    logic [15:0] v; logic cp; logic [PGW-1:0] pg;
    reg_write(P_BUFCFG, 16'h0100);
    bid(16'd1514);                              // needs 6, free 5
    reg_read(P_BUFEVT, v, cp, pg);
    check("R4 no event while short", v, 0);
    check("R4 no irq while short", irq, 0);
    done_pulse(5'd5);                           // free 10
    @(negedge clk);
    check("R4 irq after space freed", irq, 1);
    reg_read(P_BUFEVT, v, cp, pg);
    check("R4 ready event bit", v, 16'h0100);
    check("R5 commit on event read", cp, 1);
    check("R5 commit pages on event read", pg, 6); // free 4
    check("R7 irq drops after read", irq, 0);
    reg_read(P_TXEVT, v, cp, pg);
  endtask

  task automatic t_replace();
    logic [15:0] v; logic cp; logic [PGW-1:0] pg;
    bid(16'd1024);                              // 4 pages, fits
    reg_write(P_CMD, 16'h0001);
    reg_read(P_STATUS, v, cp, pg);
    check("R8 pending bid cancelled", v, 0);
    check("R8 no commit after cancel", cp, 0);
    reg_write(P_LEN, 16'd256);
    reg_read(P_STATUS, v, cp, pg);
    check("R8 new bid ready", v, 16'h0100);
    check("R8 new bid pages", pg, 1);           // free 3
  endtask

  task automatic t_txok_irq();
    logic [15:0] v; logic cp; logic [PGW-1:0] pg;
    reg_write(P_TXCFG, 16'h0100);
    check("R7 no irq before done", irq, 0);
    done_pulse(5'd1);                           // free 4
    check("R6 txok irq", irq, 1);
    reg_read(P_TXEVT, v, cp, pg);
    check("R6 txok read", v, 16'h0100);
    check("R7 irq cleared", irq, 0);
    bid(16'd1024);
    reg_read(P_STATUS, v, cp, pg);
    check("R5 accounting exact fit", v, 16'h0100);
    check("R5 exact fit pages", pg, 4);         // free 0
    bid(16'd1);
    reg_read(P_STATUS, v, cp, pg);
    check("R3 empty pool not ready", v, 0);
  endtask

  initial begin
    n_vec = 0; n_bad = 0; finished = 0;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = '0; tx_done = 1'b0; tx_done_pages = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_len_no_cmd();
    t_bad_len();
    t_polled();
    t_poll_after_free();
    t_irq_ready();
    t_replace();
    t_txok_irq();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule